// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines and presents the CPU with one interrupt output. It keeps three eight-bit registers: pending requests, levels currently in service, and a per-line mask. A priority scanner finds the highest-ranked pending request that is not masked. The interrupt output is raised only when that request outranks every level already in service.

When the CPU acknowledges, the winning level moves into the in-service register. The controller returns an eight-bit vector made of a programmable five-bit base and the three-bit level number. The CPU ends service with an end-of-interrupt command, either for the highest in-service level or for a named level.

A small register port lets the CPU load the mask, the vector base and commands, and read back any of the three registers. The port has an active-low select, active-low read and write strobes, and one address bit. Priority is either fixed or rotating, and the CPU can switch between them at any time.

Top module: `irq_ctrl8`

## Requirements
- R1: After synchronous reset, `int_out` and `vec_valid` are 0. The pending, in-service and mask registers read back as 0. The readback selector points at the pending register, the vector base is 0, and priority is fixed.
- R2: The pending register samples `irq_req` on every clock edge. After the command that selects pending readback, a read with `cpu_a0`=0 returns it. The mask does not alter the stored pending bits.
- R3: `int_out` is registered. It goes high on the second rising edge after an unmasked request line rises, provided that request outranks every in-service level.
- R4: In fixed mode, level 0 has the highest priority and level 7 the lowest.
- R5: A one-cycle `inta` pulse acts on the next rising edge. If a request qualifies, that edge sets the winner's in-service bit, loads `vec_out` with {base, level} and raises `vec_valid` for one cycle. If no request qualifies, `vec_out` is {base, 3'd7} and the in-service register is unchanged.
- R6: A set mask bit removes only its own line from arbitration. When a higher line is masked, a lower unmasked line still wins. When every line is masked, `int_out` stays low.
- R7: An in-service level blocks requests of equal and lower priority. A request of higher priority raises `int_out` again and can be acknowledged on top of it.
- R8: The non-specific end-of-interrupt command (write, `cpu_a0`=0, data 8'h10) clears the highest-priority in-service bit.
- R9: The specific end-of-interrupt command (write, `cpu_a0`=0, data bits [7:4]=4'b0011, level in bits [2:0]) clears that level's in-service bit.
- R10: Data 8'h50 selects rotating mode and data 8'h40 selects fixed mode. In rotating mode, each end-of-interrupt makes the cleared level the lowest priority. Selecting fixed mode restores level 0 as highest, and the mode may change while levels are pending.
- R11: While `cpu_cs_n` is high, writes have no effect on any register and `cpu_rdata` holds its last value.
- R12: The command encoding is as follows. A write with `cpu_a0`=1 loads the mask. A write with `cpu_a0`=0 and bit 7 set loads the vector base from bits [4:0]. Command 8'h20 selects pending readback and 8'h60 selects in-service readback. A read with `cpu_a0`=1 returns the mask. `cpu_rdata` is registered on the read edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Interrupt request lines, level sensitive |
| cpu_cs_n | input | 1 | Register port select, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_a0 | input | 1 | Register address bit |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| int_out | output | 1 | Interrupt request to the CPU |
| inta | input | 1 | Acknowledge strobe, one cycle, active high |
| vec_out | output | 8 | Vector {base, level} |
| vec_valid | output | 1 | High for one cycle when `vec_out` is updated |

## Verification
The assertions assume that `inta` is a single-cycle pulse that the CPU issues only after reset. They also assume that the CPU port strobes are synchronous to `clk` and hold their values for a whole cycle. The bench drives every input on the falling edge and raises each strobe for exactly one cycle. After each change to the request lines, it waits several cycles before acknowledging, so every acknowledge sees settled pending and interrupt state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // command opcodes carried in write data bits [6:4] when bit 7 is clear
  typedef enum logic [2:0] {
    OP_NS_EOI = 3'b001,
    OP_RD_REQ = 3'b010,
    OP_SP_EOI = 3'b011,
    OP_FIXED  = 3'b100,
    OP_ROTATE = 3'b101,
    OP_RD_SVC = 3'b110
  } cmd_op_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] low,
  output logic          any,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  logic [LW-1:0] idx;

  // scan from lowest rank to highest so the best candidate is written last
  always_comb begin
    any  = 1'b0;
    lvl  = '0;
    rank = '0;
    idx  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = low + LW'(1) + LW'(k);
      if (req[idx]) begin
        any  = 1'b1;
        lvl  = idx;
        rank = LW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_cpu_dec.sv
module irq_cpu_dec
  import irq_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       a0,
  input  logic [3:0] op_bits,
  output logic       mask_we,
  output logic       base_we,
  output logic       ns_eoi,
  output logic       sp_eoi,
  output logic       set_fixed,
  output logic       set_rot,
  output logic       sel_req,
  output logic       sel_svc,
  output logic       rd_en
);
  logic wr_en, cmd_we;
  cmd_op_e op;

  assign wr_en   = !cs_n && !wr_n;
  assign rd_en   = !cs_n && !rd_n;
  assign mask_we = wr_en && a0;
  assign base_we = wr_en && !a0 && op_bits[3];
  assign cmd_we  = wr_en && !a0 && !op_bits[3];
  assign op      = cmd_op_e'(op_bits[2:0]);

  always_comb begin
    ns_eoi    = 1'b0;
    sp_eoi    = 1'b0;
    set_fixed = 1'b0;
    set_rot   = 1'b0;
    sel_req   = 1'b0;
    sel_svc   = 1'b0;
    if (cmd_we) begin
      case (op)
        OP_NS_EOI: ns_eoi    = 1'b1;
        OP_SP_EOI: sp_eoi    = 1'b1;
        OP_FIXED:  set_fixed = 1'b1;
        OP_ROTATE: set_rot   = 1'b1;
        OP_RD_REQ: sel_req   = 1'b1;
        OP_RD_SVC: sel_svc   = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
  parameter int NUM_LVL = 8,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    irq_req,
  input  logic          cpu_cs_n,
  input  logic          cpu_rd_n,
  input  logic          cpu_wr_n,
  input  logic          cpu_a0,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          int_out,
  input  logic          inta,
  output logic [DW-1:0] vec_out,
  output logic          vec_valid
);
  localparam int LW = $clog2(NUM_LVL);
  localparam int BW = DW - LW;

  logic [NUM_LVL-1:0] pend_q, isr_q, mask_q, set_vec, clr_vec;
  logic [BW-1:0]      base_q;
  logic [LW-1:0]      low_q, eoi_lvl;
  logic               rot_q, rd_svc_q, int_q, vec_vld_q;
  logic [DW-1:0]      vec_q, rdata_q;

  logic mask_we, base_we, ns_eoi, sp_eoi, set_fixed, set_rot, sel_req, sel_svc, rd_en;
  logic req_any, svc_any, int_cond, eoi_fire;
  logic [LW-1:0] req_lvl, req_rank, svc_lvl, svc_rank;

  irq_cpu_dec u_dec (
    .cs_n(cpu_cs_n), .rd_n(cpu_rd_n), .wr_n(cpu_wr_n), .a0(cpu_a0),
    .op_bits(cpu_wdata[DW-1 -: 4]),
    .mask_we(mask_we), .base_we(base_we), .ns_eoi(ns_eoi), .sp_eoi(sp_eoi),
    .set_fixed(set_fixed), .set_rot(set_rot), .sel_req(sel_req),
    .sel_svc(sel_svc), .rd_en(rd_en)
  );

  irq_prio_pick #(.N(NUM_LVL)) u_req_pick (
    .req(pend_q & ~mask_q), .low(low_q),
    .any(req_any), .lvl(req_lvl), .rank(req_rank)
  );

  irq_prio_pick #(.N(NUM_LVL)) u_svc_pick (
    .req(isr_q), .low(low_q),
    .any(svc_any), .lvl(svc_lvl), .rank(svc_rank)
  );

  assign int_cond = req_any && (!svc_any || (req_rank < svc_rank));
  assign eoi_lvl  = sp_eoi ? cpu_wdata[LW-1:0] : svc_lvl;
  assign eoi_fire = sp_eoi || (ns_eoi && svc_any);
  assign set_vec  = (inta && int_cond) ? (NUM_LVL'(1) << req_lvl) : '0;
  assign clr_vec  = eoi_fire ? (NUM_LVL'(1) << eoi_lvl) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      isr_q     <= '0;
      mask_q    <= '0;
      base_q    <= '0;
      low_q     <= LW'(NUM_LVL - 1);
      rot_q     <= 1'b0;
      rd_svc_q  <= 1'b0;
      int_q     <= 1'b0;
      vec_q     <= '0;
      vec_vld_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      pend_q    <= irq_req[NUM_LVL-1:0];
      isr_q     <= (isr_q | set_vec) & ~clr_vec;
      int_q     <= int_cond;
      vec_vld_q <= inta;
      if (inta) vec_q <= {base_q, int_cond ? req_lvl : LW'(NUM_LVL - 1)};
      if (mask_we) mask_q <= cpu_wdata[NUM_LVL-1:0];
      if (base_we) base_q <= cpu_wdata[BW-1:0];
      if (sel_req) rd_svc_q <= 1'b0;
      else if (sel_svc) rd_svc_q <= 1'b1;
      if (set_fixed) begin
        rot_q <= 1'b0;
        low_q <= LW'(NUM_LVL - 1);
      end else if (set_rot) begin
        rot_q <= 1'b1;
      end else if (rot_q && eoi_fire) begin
        low_q <= eoi_lvl;
      end
      if (rd_en) rdata_q <= cpu_a0 ? DW'(mask_q) : DW'(rd_svc_q ? isr_q : pend_q);
    end
  end

  assign cpu_rdata = rdata_q;
  assign int_out   = int_q;
  assign vec_out   = vec_q;
  assign vec_valid = vec_vld_q;

  // R3: interrupt only follows an unmasked pending request
  p_int_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(|(pend_q & ~mask_q)));

  // R5: in-service bits are only set by an acknowledge, one at a time
  p_isr_set_needs_inta_r5: assert property (@(posedge clk) disable iff (rst)
    (|(isr_q & ~$past(isr_q))) |-> $past(inta));
  p_isr_set_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr_q & ~$past(isr_q)));

  // R6: a masked level never enters service
  p_no_masked_service_r6: assert property (@(posedge clk) disable iff (rst)
    (isr_q & ~$past(isr_q) & $past(mask_q)) == '0);

  // R9: specific end-of-interrupt clears the named level
  p_sp_eoi_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (sp_eoi && !inta) |=> !isr_q[$past(cpu_wdata[LW-1:0])]);

  // R11: deselected port leaves the mask untouched
  p_cs_guard_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_cs_n |=> $stable(mask_q));
endmodule

// File: tb/irq_ctrl8_bench.sv
`timescale 1ns/1ps
module irq_ctrl8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_req = '0;
  logic       cpu_cs_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1, cpu_a0 = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata, vec_out;
  logic       int_out, vec_valid;
  logic       inta = 1'b0;
  int checks = 0;
  int fails  = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  irq_ctrl8 u_irq_ctrl8 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .cpu_cs_n(cpu_cs_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_a0(cpu_a0),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .int_out(int_out),
    .inta(inta), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a0, input logic [7:0] d);
    @(negedge clk);
    cpu_cs_n = 1'b0; cpu_wr_n = 1'b0; cpu_a0 = a0; cpu_wdata = d;
    @(negedge clk);
    cpu_cs_n = 1'b1; cpu_wr_n = 1'b1;
  endtask

  task automatic rd(input logic a0, output logic [7:0] d);
    @(negedge clk);
    cpu_cs_n = 1'b0; cpu_rd_n = 1'b0; cpu_a0 = a0;
    @(negedge clk);
    cpu_cs_n = 1'b1; cpu_rd_n = 1'b1;
    d = cpu_rdata;
  endtask

  task automatic ack(output logic [7:0] vv);
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    chk("R5 vec_valid", {7'b0, vec_valid}, 8'h01);
    vv = vec_out;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 int_out", {7'b0, int_out}, 8'h00);
    chk("R1 vec_valid", {7'b0, vec_valid}, 8'h00);
    rd(1'b0, v); chk("R1 pending", v, 8'h00);
    rd(1'b1, v); chk("R1 mask", v, 8'h00);
    wr(1'b0, 8'h60); rd(1'b0, v); chk("R1 in-service", v, 8'h00);
    wr(1'b0, 8'h20);
  endtask

  task automatic t_basic();
    @(negedge clk); irq_req = 8'h24;
    @(negedge clk); chk("R3 not before second edge", {7'b0, int_out}, 8'h00);
    @(negedge clk); chk("R3 int raised", {7'b0, int_out}, 8'h01);
    rd(1'b0, v); chk("R2 pending readback", v, 8'h24);
    ack(v); chk("R4 fixed winner level 2", v, 8'h02);
    settle(); chk("R7 lower level blocked", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h60); rd(1'b0, v); chk("R5 in-service set", v, 8'h04);
    @(negedge clk); irq_req = 8'h25;
    settle(); chk("R7 higher level preempts", {7'b0, int_out}, 8'h01);
    ack(v); chk("R7 nested vector", v, 8'h00);
    rd(1'b0, v); chk("R7 nested in-service", v, 8'h05);
    wr(1'b0, 8'h10); rd(1'b0, v); chk("R8 non-specific eoi", v, 8'h04);
    wr(1'b0, 8'h32); rd(1'b0, v); chk("R9 specific eoi", v, 8'h00);
    @(negedge clk); irq_req = 8'h00;
    settle();
  endtask

  task automatic t_base();
    wr(1'b0, 8'h95);
    @(negedge clk); irq_req = 8'h40;
    settle();
    ack(v); chk("R12 vector base", v, 8'hAE);
    wr(1'b0, 8'h36);
    @(negedge clk); irq_req = 8'h00;
    settle();
  endtask

  task automatic t_mask();
    wr(1'b1, 8'h01); rd(1'b1, v); chk("R12 mask readback", v, 8'h01);
    @(negedge clk); irq_req = 8'h21;
    settle(); chk("R6 lower line still raises", {7'b0, int_out}, 8'h01);
    wr(1'b0, 8'h20); rd(1'b0, v); chk("R2 mask leaves pending", v, 8'h21);
    ack(v); chk("R6 masked high line skipped", v, 8'hAD);
    wr(1'b0, 8'h35);
    wr(1'b1, 8'hFF);
    settle(); chk("R6 all masked", {7'b0, int_out}, 8'h00);
    ack(v); chk("R5 spurious vector", v, 8'hAF);
    wr(1'b0, 8'h60); rd(1'b0, v); chk("R5 spurious no service", v, 8'h00);
    wr(1'b1, 8'h00);
    @(negedge clk); irq_req = 8'h00;
    settle();
  endtask

  task automatic t_rotate();
    wr(1'b0, 8'h50);
    @(negedge clk); irq_req = 8'h18;
    settle();
    ack(v); chk("R10 first winner", v, 8'hAB);
    wr(1'b0, 8'h10); settle();
    ack(v); chk("R10 rotated to level 4", v, 8'hAC);
    wr(1'b0, 8'h10); settle();
    ack(v); chk("R10 rotated back to level 3", v, 8'hAB);
    wr(1'b0, 8'h10);
    wr(1'b0, 8'h40); settle();
    ack(v); chk("R10 fixed mode restored", v, 8'hAB);
    wr(1'b0, 8'h10);
    @(negedge clk); irq_req = 8'h00;
    settle();
  endtask

  task automatic t_deselect();
    @(negedge clk);
    cpu_cs_n = 1'b1; cpu_wr_n = 1'b0; cpu_a0 = 1'b1; cpu_wdata = 8'hFF;
    @(negedge clk);
    cpu_wr_n = 1'b1;
    rd(1'b1, v); chk("R11 write ignored", v, 8'h00);
    wr(1'b1, 8'h5A);
    @(negedge clk);
    cpu_cs_n = 1'b1; cpu_rd_n = 1'b0; cpu_a0 = 1'b1;
    @(negedge clk);
    cpu_rd_n = 1'b1;
    chk("R11 rdata held", cpu_rdata, 8'h00);
    rd(1'b1, v); chk("R12 mask after select", v, 8'h5A);
    wr(1'b1, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_base();
    t_mask();
    t_rotate();
    t_deselect();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule